// File: doc/BRIEF.md
# Debug Breakpoint Qualification Filter

This block sits between the match comparators of a processor debug unit and the places their results go: the breakpoint request lines into the core, the external watchpoint pins and the count-enable lines of the debug event counters. Each cycle it takes raw match strobes for four kinds of event. These are plain instruction breakpoints, load/store breakpoints, counter-generated breakpoints of both kinds, and watchpoints. It also takes the processor's recoverable-interrupt status bit. From these it decides which events are passed on.

Two small state machines hold the control state. The mode machine has states MODE_MASKED and MODE_OPEN. Reset leaves it in MODE_MASKED. A write with the no-mask bit set takes it from MODE_MASKED to MODE_OPEN, and a write with that bit clear takes it back. In MODE_MASKED, events seen while the recoverable bit is low are discarded. The skip machine has states SKIP_IDLE and SKIP_ARMED. A write with the skip bit set takes it from SKIP_IDLE to SKIP_ARMED. A write with that bit clear takes it from SKIP_ARMED back to SKIP_IDLE. It also returns from SKIP_ARMED to SKIP_IDLE by itself when it swallows one qualified plain instruction breakpoint. Software reaches both bits through one control register at address CTRL_ADDR: bit 0 is the no-mask bit and bit 1 is the skip bit.

Top module: `bkpt_qual_filter`

## Requirements
- R1: After reset all outputs are low, and reading CTRL_ADDR returns 0: the no-mask bit (bit 0) is clear and the skip bit (bit 1) is clear.
- R2: With the no-mask bit clear and msr_ri low, no breakpoint of any kind is raised: plain, counter-generated, instruction or load/store.
- R3: A breakpoint match that qualifies raises its request one clock later as a one-cycle pulse. A match qualifies when the no-mask bit is set or msr_ri is high. A plain or counter-generated instruction match drives ibrk_req. A plain or counter-generated load/store match drives lbrk_req.
- R4: With the no-mask bit set, both instruction and load/store breakpoints are raised while msr_ri is low.
- R5: wp_pins equals wp_match from the previous cycle, whatever the mode and msr_ri.
- R6: wp_cnt_en equals the previous cycle's wp_match when that match qualified, and is zero otherwise.
- R7: While the skip bit is set, the first qualified plain instruction match raises no request, and the skip bit reads 0 on the following cycle.
- R8: While the skip bit is clear, every qualified plain instruction match raises ibrk_req.
- R9: Load/store and counter-generated matches raise requests while the skip bit is set, and they leave that bit unchanged.
- R10: A write that sets the skip bit in the same cycle that hardware would clear it leaves the bit set.
- R11: Reads at any address other than CTRL_ADDR return 0, and writes there change no state.
- R12: A plain instruction match discarded by R2 leaves the skip bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control write enable |
| cfg_addr | input | ADDR_W | Control address |
| cfg_wdata | input | DATA_W | Write data (bit 0 no-mask, bit 1 skip) |
| cfg_rdata | output | DATA_W | Read data for cfg_addr, combinational |
| msr_ri | input | 1 | Processor recoverable-interrupt status |
| ibp_match | input | N_IBP | Plain instruction breakpoint matches |
| lbp_match | input | N_LBP | Plain load/store breakpoint matches |
| cnt_ibp_match | input | N_CNT | Counter-generated instruction breakpoints |
| cnt_lbp_match | input | N_CNT | Counter-generated load/store breakpoints |
| wp_match | input | N_WP | Watchpoint matches |
| ibrk_req | output | 1 | Instruction breakpoint request to core |
| lbrk_req | output | 1 | Load/store breakpoint request to core |
| wp_pins | output | N_WP | External watchpoint pins |
| wp_cnt_en | output | N_WP | Debug counter advance enables |

## Verification
The hardest situations to reach are those where the skip machine in SKIP_ARMED meets a second event in the same cycle. That event may be a software write that re-arms the bit, a counter-generated instruction match that must still pass, or a match discarded by the mask. Random stimulus seldom produces these combinations in the right order, so directed sequences first arm the bit and then apply each collision. A long random run then varies msr_ri, the mode and sparse match patterns against a bench model.

// File: rtl/bqf_pkg.sv
package bqf_pkg;
    typedef enum logic {MODE_MASKED = 1'b0, MODE_OPEN = 1'b1} mode_e;
    typedef enum logic {SKIP_IDLE = 1'b0, SKIP_ARMED = 1'b1} skip_e;
    localparam int NOMASK_BIT = 0;
    localparam int SKIP_BIT   = 1;
endpackage

// File: rtl/bqf_ctrl_regs.sv
module bqf_ctrl_regs
    import bqf_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              skip_consume,
    output mode_e             mode,
    output skip_e             skip,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    mode_e mode_q, mode_nx;
    skip_e skip_q, skip_nx;
    logic  hit;

    assign hit = we && (addr == CTRL_A);

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_MASKED;
            skip_q <= SKIP_IDLE;
        end else begin
            mode_q <= mode_nx;
            skip_q <= skip_nx;
        end
    end

    // next-state logic
    always_comb begin
        mode_nx = mode_q;
        unique case (mode_q)
            MODE_MASKED: if (hit && wdata[NOMASK_BIT])  mode_nx = MODE_OPEN;
            MODE_OPEN:   if (hit && !wdata[NOMASK_BIT]) mode_nx = MODE_MASKED;
            default:     mode_nx = MODE_MASKED;
        endcase
        skip_nx = skip_q;
        unique case (skip_q)
            SKIP_IDLE:  if (hit && wdata[SKIP_BIT]) skip_nx = SKIP_ARMED;
            SKIP_ARMED: begin
                if (hit)               skip_nx = wdata[SKIP_BIT] ? SKIP_ARMED : SKIP_IDLE;
                else if (skip_consume) skip_nx = SKIP_IDLE;
            end
            default:    skip_nx = SKIP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rdata = '0;
        if (addr == CTRL_A) begin
            rdata[NOMASK_BIT] = (mode_q == MODE_OPEN);
            rdata[SKIP_BIT]   = (skip_q == SKIP_ARMED);
        end
    end

    assign mode = mode_q;
    assign skip = skip_q;
endmodule

// File: rtl/bqf_qualify.sv
module bqf_qualify
    import bqf_pkg::*;
#(
    parameter int N_IBP = 4,
    parameter int N_LBP = 2,
    parameter int N_CNT = 2,
    parameter int N_WP  = 4
) (
    input  mode_e            mode,
    input  skip_e            skip,
    input  logic             msr_ri,
    input  logic [N_IBP-1:0] ibp,
    input  logic [N_LBP-1:0] lbp,
    input  logic [N_CNT-1:0] cibp,
    input  logic [N_CNT-1:0] clbp,
    input  logic [N_WP-1:0]  wp,
    output logic             ibrk_nx,
    output logic             lbrk_nx,
    output logic [N_WP-1:0]  pin_nx,
    output logic [N_WP-1:0]  cnt_nx,
    output logic             skip_consume
);
    logic pass, plain_i;

    assign pass    = (mode == MODE_OPEN) || msr_ri;
    assign plain_i = (|ibp) && pass;

    always_comb begin
        skip_consume = 1'b0;
        ibrk_nx      = (|cibp) && pass;
        unique case (skip)
            SKIP_ARMED: skip_consume = plain_i;
            SKIP_IDLE:  ibrk_nx      = ibrk_nx || plain_i;
            default:    ;
        endcase
        lbrk_nx = ((|lbp) || (|clbp)) && pass;
    end

    for (genvar g = 0; g < N_WP; g++) begin : g_wp
        assign pin_nx[g] = wp[g];
        assign cnt_nx[g] = wp[g] && pass;
    end
endmodule

// File: rtl/bqf_out_stage.sv
module bqf_out_stage #(
    parameter int N_WP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ibrk_nx,
    input  logic            lbrk_nx,
    input  logic [N_WP-1:0] pin_nx,
    input  logic [N_WP-1:0] cnt_nx,
    output logic            ibrk_q,
    output logic            lbrk_q,
    output logic [N_WP-1:0] pin_q,
    output logic [N_WP-1:0] cnt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ibrk_q <= 1'b0;
            lbrk_q <= 1'b0;
            pin_q  <= '0;
            cnt_q  <= '0;
        end else begin
            ibrk_q <= ibrk_nx;
            lbrk_q <= lbrk_nx;
            pin_q  <= pin_nx;
            cnt_q  <= cnt_nx;
        end
    end
endmodule

// File: rtl/bkpt_qual_filter.sv
module bkpt_qual_filter
    import bqf_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 0,
    parameter int N_IBP     = 4,
    parameter int N_LBP     = 2,
    parameter int N_CNT     = 2,
    parameter int N_WP      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              msr_ri,
    input  logic [N_IBP-1:0]  ibp_match,
    input  logic [N_LBP-1:0]  lbp_match,
    input  logic [N_CNT-1:0]  cnt_ibp_match,
    input  logic [N_CNT-1:0]  cnt_lbp_match,
    input  logic [N_WP-1:0]   wp_match,
    output logic              ibrk_req,
    output logic              lbrk_req,
    output logic [N_WP-1:0]   wp_pins,
    output logic [N_WP-1:0]   wp_cnt_en
);
    mode_e           mode;
    skip_e           skip;
    logic            skip_consume;
    logic            ibrk_nx, lbrk_nx;
    logic [N_WP-1:0] pin_nx, cnt_nx;
    logic            mode_open, skip_armed;

    assign mode_open  = (mode == MODE_OPEN);
    assign skip_armed = (skip == SKIP_ARMED);

    bqf_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .skip_consume(skip_consume), .mode(mode), .skip(skip), .rdata(cfg_rdata)
    );

    bqf_qualify #(.N_IBP(N_IBP), .N_LBP(N_LBP), .N_CNT(N_CNT), .N_WP(N_WP)) u_qual (
        .mode(mode), .skip(skip), .msr_ri(msr_ri), .ibp(ibp_match), .lbp(lbp_match),
        .cibp(cnt_ibp_match), .clbp(cnt_lbp_match), .wp(wp_match),
        .ibrk_nx(ibrk_nx), .lbrk_nx(lbrk_nx), .pin_nx(pin_nx), .cnt_nx(cnt_nx),
        .skip_consume(skip_consume)
    );

    bqf_out_stage #(.N_WP(N_WP)) u_out (
        .clk(clk), .rst_n(rst_n), .ibrk_nx(ibrk_nx), .lbrk_nx(lbrk_nx),
        .pin_nx(pin_nx), .cnt_nx(cnt_nx), .ibrk_q(ibrk_req), .lbrk_q(lbrk_req),
        .pin_q(wp_pins), .cnt_q(wp_cnt_en)
    );
endmodule

// File: rtl/bqf_checker.sv
module bqf_checker #(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int N_IBP     = 4,
    parameter int N_LBP     = 2,
    parameter int N_CNT     = 2,
    parameter int N_WP      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              wr_skip,
    input logic              msr_ri,
    input logic [N_IBP-1:0]  ibp_match,
    input logic [N_LBP-1:0]  lbp_match,
    input logic [N_CNT-1:0]  cnt_ibp_match,
    input logic [N_CNT-1:0]  cnt_lbp_match,
    input logic [N_WP-1:0]   wp_match,
    input logic              ibrk_req,
    input logic              lbrk_req,
    input logic [N_WP-1:0]   wp_pins,
    input logic [N_WP-1:0]   wp_cnt_en,
    input logic              mode_open,
    input logic              skip_armed
);
    logic hit;
    assign hit = cfg_we && (cfg_addr == ADDR_W'(CTRL_ADDR));

    // R2
    mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_open && !msr_ri) |=> (!ibrk_req && !lbrk_req));
    // R3
    ls_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((|lbp_match) || (|cnt_lbp_match)) && (mode_open || msr_ri)) |=> lbrk_req);
    // R3
    i_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ibp_match == '0) && (cnt_ibp_match == '0)) |=> !ibrk_req);
    // R5
    pin_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wp_pins == $past(wp_match)));
    // R6
    cnt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mode_open) && !$past(msr_ri)) |-> (wp_cnt_en == '0));
    // R7
    skip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_armed && (|ibp_match) && (mode_open || msr_ri) && !hit) |=> !skip_armed);
    // R10
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_skip) |=> skip_armed);
    // R12
    masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_armed && !mode_open && !msr_ri && !hit) |=> skip_armed);
endmodule

bind bkpt_qual_filter bqf_checker #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .N_IBP(N_IBP),
    .N_LBP(N_LBP), .N_CNT(N_CNT), .N_WP(N_WP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .wr_skip(cfg_wdata[bqf_pkg::SKIP_BIT]), .msr_ri(msr_ri),
    .ibp_match(ibp_match), .lbp_match(lbp_match),
    .cnt_ibp_match(cnt_ibp_match), .cnt_lbp_match(cnt_lbp_match),
    .wp_match(wp_match), .ibrk_req(ibrk_req), .lbrk_req(lbrk_req),
    .wp_pins(wp_pins), .wp_cnt_en(wp_cnt_en),
    .mode_open(mode_open), .skip_armed(skip_armed)
);

// File: tb/sim_bkpt_qual_filter.sv
module sim_bkpt_qual_filter;
    localparam int ADDR_W = 4, DATA_W = 8, N_IBP = 4, N_LBP = 2, N_CNT = 2, N_WP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic [DATA_W-1:0] cfg_rdata;
    logic msr_ri = 1'b0;
    logic [N_IBP-1:0] ibp_match = '0;
    logic [N_LBP-1:0] lbp_match = '0;
    logic [N_CNT-1:0] cnt_ibp_match = '0;
    logic [N_CNT-1:0] cnt_lbp_match = '0;
    logic [N_WP-1:0]  wp_match = '0;
    logic ibrk_req, lbrk_req;
    logic [N_WP-1:0] wp_pins, wp_cnt_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit m_open = 1'b0;
    bit m_skip = 1'b0;

    always #2 clk = ~clk;

    bkpt_qual_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msr_ri(msr_ri),
        .ibp_match(ibp_match), .lbp_match(lbp_match),
        .cnt_ibp_match(cnt_ibp_match), .cnt_lbp_match(cnt_lbp_match),
        .wp_match(wp_match), .ibrk_req(ibrk_req), .lbrk_req(lbrk_req),
        .wp_pins(wp_pins), .wp_cnt_en(wp_cnt_en)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DATA_W-1:0] exp_rd(input logic [ADDR_W-1:0] a);
        exp_rd = '0;
        if (a == '0) begin
            exp_rd[0] = m_open;
            exp_rd[1] = m_skip;
        end
    endfunction

    task automatic cyc(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                       input bit ri, input logic [N_IBP-1:0] ib, input logic [N_LBP-1:0] lb,
                       input logic [N_CNT-1:0] ci, input logic [N_CNT-1:0] cl,
                       input logic [N_WP-1:0] wp, input string tag);
        bit pass, plain, e_i, e_l, hit, n_skip, n_open;
        string ti;
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = wd; msr_ri = ri;
        ibp_match = ib; lbp_match = lb; cnt_ibp_match = ci; cnt_lbp_match = cl; wp_match = wp;
        pass  = m_open || ri;
        plain = (|ib) && pass;
        e_i   = (plain && !m_skip) || ((|ci) && pass);
        e_l   = ((|lb) || (|cl)) && pass;
        hit   = we && (a == '0);
        n_open = hit ? wd[0] : m_open;
        n_skip = hit ? wd[1] : ((plain && m_skip) ? 1'b0 : m_skip);
        if (tag != "") ti = tag;
        else if (!pass) ti = "R2";
        else if (m_skip && plain) ti = "R7";
        else if (!m_skip && plain) ti = "R8";
        else ti = "R3";
        @(posedge clk);
        #1;
        m_open = n_open;
        m_skip = n_skip;
        chk(ibrk_req == e_i, ti, 32'(ibrk_req), 32'(e_i));
        chk(lbrk_req == e_l, ti, 32'(lbrk_req), 32'(e_l));
        chk(wp_pins == wp, "R5", 32'(wp_pins), 32'(wp));
        chk(wp_cnt_en == (pass ? wp : '0), "R6", 32'(wp_cnt_en), 32'(pass ? wp : '0));
        chk(cfg_rdata == exp_rd(a), (tag != "") ? tag : "R11", 32'(cfg_rdata), 32'(exp_rd(a)));
    endtask

    task automatic idle(input bit ri);
        cyc(1'b0, '0, '0, ri, '0, '0, '0, '0, '0, "");
    endtask

    task automatic wr(input logic [DATA_W-1:0] d);
        cyc(1'b1, '0, d, 1'b1, '0, '0, '0, '0, '0, "");
    endtask

    initial begin
        void'($urandom(32'd24601));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(!ibrk_req && !lbrk_req, "R1", 32'({ibrk_req, lbrk_req}), 0);
        chk(wp_pins == '0 && wp_cnt_en == '0, "R1", 32'({wp_pins, wp_cnt_en}), 0);
        chk(cfg_rdata == '0, "R1", 32'(cfg_rdata), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 masked, ri low: all breakpoints discarded, watch pins still driven
        cyc(0, '0, '0, 0, 4'h1, 2'h1, 2'h1, 2'h1, 4'hF, "R2");
        idle(1);
        // R3 qualified by ri
        cyc(0, '0, '0, 1, 4'h2, 2'h2, '0, '0, 4'h5, "R3");
        idle(1);
        // R4 open mode raises both with ri low
        wr(8'h01);
        cyc(0, '0, '0, 0, 4'h8, 2'h1, '0, '0, 4'hA, "R4");
        idle(0);
        // R8 skip clear, repeated instruction matches each raise
        cyc(0, '0, '0, 0, 4'h1, '0, '0, '0, '0, "R8");
        cyc(0, '0, '0, 0, 4'h1, '0, '0, '0, '0, "R8");
        // R7 first match swallowed, second raised
        wr(8'h03);
        cyc(0, '0, '0, 0, 4'h4, '0, '0, '0, '0, "R7");
        cyc(0, '0, '0, 0, 4'h4, '0, '0, '0, '0, "R7");
        // R9 load/store and counter-generated pass while armed, bit kept
        wr(8'h03);
        cyc(0, '0, '0, 1, '0, 2'h1, 2'h2, 2'h1, '0, "R9");
        cyc(0, '0, '0, 1, 4'h1, '0, 2'h1, '0, '0, "R9");
        // R10 write re-arms in the collision cycle
        wr(8'h03);
        cyc(1, '0, 8'h03, 1, 4'h2, '0, '0, '0, '0, "R10");
        idle(1);
        // R12 masked discard keeps skip armed
        wr(8'h02);
        cyc(0, '0, '0, 0, 4'h1, '0, '0, '0, '0, "R12");
        cyc(0, '0, '0, 1, 4'h1, '0, '0, '0, '0, "R7");
        // R11 other address: reads zero, write ignored
        cyc(1, 4'h3, 8'h03, 1, '0, '0, '0, '0, '0, "R11");
        idle(0);
        cyc(0, '0, '0, 0, 4'h1, '0, '0, '0, '0, "R11");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            bit we;
            logic [ADDR_W-1:0] a;
            we = ($urandom % 8) == 0;
            a  = (($urandom % 4) == 0) ? ADDR_W'($urandom % 4) : '0;
            cyc(we, a, DATA_W'($urandom), 1'($urandom),
                (($urandom % 3) == 0) ? N_IBP'($urandom) : '0,
                (($urandom % 4) == 0) ? N_LBP'($urandom) : '0,
                (($urandom % 6) == 0) ? N_CNT'($urandom) : '0,
                (($urandom % 6) == 0) ? N_CNT'($urandom) : '0,
                N_WP'($urandom), "");
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule